// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block performs the context switch of a processor whose general registers live in memory, in a region named by a workspace pointer (WP). It has three entry points. The first is a swap to a new context through a two-word vector at an effective address that an earlier stage has already computed. The second is a return to the context saved by the last swap. The third is reset entry, which is a swap through the vector at address 0. The block owns the WP, program counter (PC) and status (ST) registers. It reaches memory through a single 16-bit word port that uses a request/ready handshake.

On a swap, the block reads the new WP and the new PC from the vector. It then stores the old WP, PC and ST into registers 13, 14 and 15 of the new workspace, in that order. Only after those writes does it install the new WP and PC. A return reads registers 13, 14 and 15 of the current workspace and loads WP, PC and ST from them. Workspace register n sits at byte address WP + 2n. Every memory address leaves the port with bit 0 cleared.

Top module: `ctxsw_seq`

## Requirements
- R1: After reset is released, the block starts a swap through byte address 0 on its own. The old context it saves is the reset state: WP, PC and ST all 0x0000.
- R2: A swap reads first at the effective address and then at the effective address plus 2. The first word read becomes the new WP and the second becomes the new PC. Address bit 0 is always driven 0.
- R3: After the two reads, a swap writes the old WP to new WP + 26, then the old PC to new WP + 28, then the old ST to new WP + 30. All three values are the ones held before the switch began.
- R4: WP, PC and ST keep their values for the whole sequence. They change only in the cycle where done is high.
- R5: A return reads current WP + 26, + 28 and + 30 in that order, all based on the pre-return WP. It loads WP, PC and ST from those words in the same order. It issues no write.
- R6: A swap leaves ST unchanged.
- R7: While mem_req is high and mem_rdy is low, the address, write enable and write data hold steady. Each access ends in the first cycle where mem_req and mem_rdy are both high.
- R8: busy is high from the cycle after a request is taken until the last access completes. done is a one-cycle pulse in the following cycle, with busy low.
- R9: swap_req and ret_req are ignored while busy is high. They are not queued.
- R10: If swap_req and ret_req are both high in an idle cycle, the swap is performed.
- R11: Asserting rst_n low aborts any sequence in progress and clears WP, PC and ST to 0x0000. On release, the R1 entry follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_req | input | 1 | Start a swap through the vector at swap_ea |
| swap_ea | input | 16 | Effective address of the two-word vector |
| ret_req | input | 1 | Start a return from the current workspace |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address, bit 0 always 0 |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when mem_rdy is high |
| mem_rdy | input | 1 | Access completes this cycle |
| wp | output | 16 | Workspace pointer |
| pc | output | 16 | Program counter |
| st | output | 16 | Status word |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle pulse when the new context is in place |

## Verification
Two of the block's functions can meet in one cycle. The first pair is a swap request and a return request in the same idle cycle. The bench raises both together and judges the outcome by the first address on the memory port, which must be the vector address rather than register 13 of the current workspace, and by the final WP and PC. The second pair is a new request against a running sequence. The bench pulses swap_req two cycles into a return and checks three things: the access log holds only the three return reads, the context matches the return values, and busy stays low afterwards. A third collision, reset falling in the middle of a swap with wait states, is judged by the cleared registers and by the boot sequence that follows.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  localparam int WORD_W = 16;
  localparam int SLOTS  = 3;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_VEC_WP,
    PH_VEC_PC,
    PH_SAVE_WP,
    PH_SAVE_PC,
    PH_SAVE_ST,
    PH_RET_WP,
    PH_RET_PC,
    PH_RET_ST
  } phase_e;

  // clear the byte-select bit of an address
  function automatic word_t word_align(input word_t a);
    return {a[WORD_W-1:1], 1'b0};
  endfunction

  // byte address of workspace register idx
  function automatic word_t reg_slot(input word_t wp, input int unsigned idx);
    return word_align(wp + word_t'(idx * 2));
  endfunction

  // address of the word following a
  function automatic word_t next_word(input word_t a);
    return word_align(a + word_t'(2));
  endfunction

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_VEC_WP:  return PH_VEC_PC;
      PH_VEC_PC:  return PH_SAVE_WP;
      PH_SAVE_WP: return PH_SAVE_PC;
      PH_SAVE_PC: return PH_SAVE_ST;
      PH_RET_WP:  return PH_RET_PC;
      PH_RET_PC:  return PH_RET_ST;
      default:    return PH_IDLE;
    endcase
  endfunction

  function automatic logic is_final(input phase_e p);
    return (p == PH_SAVE_ST) || (p == PH_RET_ST);
  endfunction

  function automatic logic is_write(input phase_e p);
    return (p == PH_SAVE_WP) || (p == PH_SAVE_PC) || (p == PH_SAVE_ST);
  endfunction

  function automatic logic is_return(input phase_e p);
    return (p == PH_RET_WP) || (p == PH_RET_PC) || (p == PH_RET_ST);
  endfunction

endpackage

// File: rtl/ctxsw_ctrl.sv
module ctxsw_ctrl
  import ctxsw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   swap_req,
  input  logic   ret_req,
  input  logic   xfer,
  output phase_e phase,
  output logic   start_swap,
  output logic   from_boot,
  output logic   start_ret,
  output logic   final_xfer,
  output logic   done
);

  phase_e phase_q;
  logic   boot_q;
  logic   done_q;
  logic   idle;

  assign idle       = (phase_q == PH_IDLE);
  assign from_boot  = idle && boot_q;
  assign start_swap = idle && (boot_q || swap_req);
  assign start_ret  = idle && !boot_q && !swap_req && ret_req;
  assign final_xfer = xfer && is_final(phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      boot_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= final_xfer;
      if (start_swap) begin
        phase_q <= PH_VEC_WP;
        boot_q  <= 1'b0;
      end else if (start_ret) begin
        phase_q <= PH_RET_WP;
      end else if (xfer) begin
        phase_q <= phase_after(phase_q);
      end
    end
  end

  assign phase = phase_q;
  assign done  = done_q;

endmodule

// File: rtl/ctxsw_state.sv
module ctxsw_state
  import ctxsw_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_VEC = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   start_swap,
  input  logic   from_boot,
  input  word_t  swap_ea,
  input  logic   xfer,
  input  word_t  rdata,
  output word_t  wp,
  output word_t  pc,
  output word_t  st,
  output word_t  ea,
  output word_t  new_wp,
  output word_t  old_wp,
  output word_t  old_pc,
  output word_t  old_st
);

  word_t wp_q, pc_q, st_q;
  word_t ea_q;
  word_t nwp_q, npc_q;
  word_t owp_q, opc_q, ost_q;

  // old context is snapshotted when a swap starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= RESET_VEC;
      owp_q <= '0;
      opc_q <= '0;
      ost_q <= '0;
    end else if (start_swap) begin
      ea_q  <= from_boot ? RESET_VEC : swap_ea;
      owp_q <= wp_q;
      opc_q <= pc_q;
      ost_q <= st_q;
    end
  end

  // fetched words are staged; the live context changes only on the last access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      pc_q  <= '0;
      st_q  <= '0;
      nwp_q <= '0;
      npc_q <= '0;
    end else if (xfer) begin
      case (phase)
        PH_VEC_WP, PH_RET_WP: nwp_q <= rdata;
        PH_VEC_PC, PH_RET_PC: npc_q <= rdata;
        PH_SAVE_ST: begin
          wp_q <= nwp_q;
          pc_q <= npc_q;
        end
        PH_RET_ST: begin
          wp_q <= nwp_q;
          pc_q <= npc_q;
          st_q <= rdata;
        end
        default: ;
      endcase
    end
  end

  assign wp     = wp_q;
  assign pc     = pc_q;
  assign st     = st_q;
  assign ea     = ea_q;
  assign new_wp = nwp_q;
  assign old_wp = owp_q;
  assign old_pc = opc_q;
  assign old_st = ost_q;

endmodule

// File: rtl/ctxsw_port.sv
module ctxsw_port
  import ctxsw_pkg::*;
#(
  parameter int LINK_REG = 13
) (
  input  phase_e phase,
  input  word_t  ea,
  input  word_t  wp,
  input  word_t  new_wp,
  input  word_t  old_wp,
  input  word_t  old_pc,
  input  word_t  old_st,
  output logic   mem_req,
  output logic   mem_we,
  output word_t  mem_addr,
  output word_t  mem_wdata
);

  word_t slot_new [SLOTS];
  word_t slot_cur [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_new[g] = reg_slot(new_wp, LINK_REG + g);
    assign slot_cur[g] = reg_slot(wp, LINK_REG + g);
  end

  assign mem_req = (phase != PH_IDLE);
  assign mem_we  = is_write(phase);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (phase)
      PH_VEC_WP:  mem_addr = word_align(ea);
      PH_VEC_PC:  mem_addr = next_word(ea);
      PH_SAVE_WP: begin mem_addr = slot_new[0]; mem_wdata = old_wp; end
      PH_SAVE_PC: begin mem_addr = slot_new[1]; mem_wdata = old_pc; end
      PH_SAVE_ST: begin mem_addr = slot_new[2]; mem_wdata = old_st; end
      PH_RET_WP:  mem_addr = slot_cur[0];
      PH_RET_PC:  mem_addr = slot_cur[1];
      PH_RET_ST:  mem_addr = slot_cur[2];
      default: ;
    endcase
  end

endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int                LINK_REG  = 13,
  parameter logic [WORD_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_req,
  input  logic [WORD_W-1:0] swap_ea,
  input  logic              ret_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic [WORD_W-1:0] wp,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] st,
  output logic              busy,
  output logic              done
);

  phase_e phase;
  logic   start_swap, from_boot, start_ret;
  logic   final_xfer;
  logic   xfer;
  logic   ret_active;
  word_t  ea, new_wp, old_wp, old_pc, old_st;

  assign xfer       = mem_req && mem_rdy;
  assign ret_active = is_return(phase);
  assign busy       = mem_req;

  ctxsw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap_req   (swap_req),
    .ret_req    (ret_req),
    .xfer       (xfer),
    .phase      (phase),
    .start_swap (start_swap),
    .from_boot  (from_boot),
    .start_ret  (start_ret),
    .final_xfer (final_xfer),
    .done       (done)
  );

  ctxsw_state #(.RESET_VEC(RESET_VEC)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .start_swap (start_swap),
    .from_boot  (from_boot),
    .swap_ea    (swap_ea),
    .xfer       (xfer),
    .rdata      (mem_rdata),
    .wp         (wp),
    .pc         (pc),
    .st         (st),
    .ea         (ea),
    .new_wp     (new_wp),
    .old_wp     (old_wp),
    .old_pc     (old_pc),
    .old_st     (old_st)
  );

  ctxsw_port #(.LINK_REG(LINK_REG)) u_port (
    .phase     (phase),
    .ea        (ea),
    .wp        (wp),
    .new_wp    (new_wp),
    .old_wp    (old_wp),
    .old_pc    (old_pc),
    .old_st    (old_st),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // start_ret is consumed only inside the controller
  logic unused_start_ret;
  assign unused_start_ret = start_ret;

endmodule

// File: rtl/ctxsw_seq_chk.sv
module ctxsw_seq_chk
  import ctxsw_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  swap_req,
  input logic  ret_req,
  input logic  mem_req,
  input logic  mem_we,
  input word_t mem_addr,
  input word_t mem_wdata,
  input logic  mem_rdy,
  input word_t wp,
  input word_t pc,
  input word_t st,
  input logic  busy,
  input logic  done,
  input logic  final_xfer,
  input logic  ret_active
);

  assert_addr_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  assert_ctx_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wp) || !$stable(pc) || !$stable(st)) |-> done);

  assert_no_write_on_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_active |-> (mem_req && !mem_we));

  assert_hold_while_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    final_xfer |=> (done && !busy));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (swap_req || ret_req)) |=> busy);

endmodule

bind ctxsw_seq ctxsw_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .swap_req   (swap_req),
  .ret_req    (ret_req),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rdy    (mem_rdy),
  .wp         (wp),
  .pc         (pc),
  .st         (st),
  .busy       (busy),
  .done       (done),
  .final_xfer (final_xfer),
  .ret_active (ret_active)
);

// File: tb/ctxsw_seq_bench.sv
module ctxsw_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_req = 1'b0;
  logic [15:0] swap_ea = '0;
  logic        ret_req = 1'b0;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] wp, pc, st;
  logic        busy, done;

  always #2.5 clk = ~clk;

  ctxsw_seq u_ctxsw_seq (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .swap_ea(swap_ea),
    .ret_req(ret_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .wp(wp), .pc(pc), .st(st), .busy(busy), .done(done)
  );

  // memory model with wait states and an access log
  logic [15:0] mem [0:2047];
  logic        poke_en = 1'b0;
  logic [15:0] poke_a = '0, poke_d = '0;
  int          wait_cfg = 0;
  int          wcnt = 0;
  logic        log_we [0:255];
  logic [15:0] log_addr [0:255];
  logic [15:0] log_data [0:255];
  int          log_n = 0;

  assign mem_rdata = mem[mem_addr[11:1]];
  assign mem_rdy   = mem_req && (wcnt == wait_cfg);

  always @(posedge clk) begin
    if (poke_en) mem[poke_a[11:1]] <= poke_d;
    if (rst_n && mem_req && mem_rdy) begin
      if (mem_we) mem[mem_addr[11:1]] <= mem_wdata;
      log_we[log_n[7:0]]   <= mem_we;
      log_addr[log_n[7:0]] <= mem_addr;
      log_data[log_n[7:0]] <= mem_we ? mem_wdata : mem_rdata;
      log_n <= log_n + 1;
    end
    if (mem_req && !mem_rdy) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_acc(input string tag, input int idx, input logic we, input logic [15:0] a, input logic [15:0] d);
    chk(tag, $sformatf("access %0d write", idx), 16'(log_we[idx[7:0]]), 16'(we));
    chk(tag, $sformatf("access %0d addr", idx), log_addr[idx[7:0]], a);
    chk(tag, $sformatf("access %0d data", idx), log_data[idx[7:0]], d);
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // runs from the current negedge until done; counts busy cycles, checks the context stays frozen
  task automatic wait_done(output int busy_cyc, output logic frozen);
    logic [15:0] w0, p0, s0;
    int guard;
    w0 = wp; p0 = pc; s0 = st;
    busy_cyc = 0; frozen = 1'b1; guard = 0;
    while (!done && guard < 500) begin
      if (busy) busy_cyc++;
      if (wp !== w0 || pc !== p0 || st !== s0) frozen = 1'b0;
      guard++;
      @(negedge clk);
    end
    chk("R8", "done seen", 16'(done), 16'd1);
    chk("R8", "busy low with done", 16'(busy), 16'd0);
    @(negedge clk);
    chk("R8", "done one cycle", 16'(done), 16'd0);
  endtask

  task automatic pulse_swap(input logic [15:0] ea, input logic with_ret);
    @(negedge clk);
    swap_req = 1'b1; swap_ea = ea; ret_req = with_ret;
    @(negedge clk);
    swap_req = 1'b0; ret_req = 1'b0;
  endtask

  task automatic t_reset_entry;
    int bc; logic fz; int base;
    chk("R11", "reset busy", 16'(busy), 16'd0);
    chk("R11", "reset mem_req", 16'(mem_req), 16'd0);
    chk("R11", "reset wp", wp, 16'h0000);
    chk("R11", "reset pc", pc, 16'h0000);
    chk("R11", "reset st", st, 16'h0000);
    poke(16'h0000, 16'h0100);
    poke(16'h0002, 16'h0200);
    base = log_n;
    @(negedge clk); rst_n = 1'b1;
    wait_done(bc, fz);
    chk("R1", "boot accesses", 16'(log_n - base), 16'd5);
    chk_acc("R1", base,   1'b0, 16'h0000, 16'h0100);
    chk_acc("R1", base+1, 1'b0, 16'h0002, 16'h0200);
    chk_acc("R1", base+2, 1'b1, 16'h011A, 16'h0000);
    chk_acc("R1", base+3, 1'b1, 16'h011C, 16'h0000);
    chk_acc("R1", base+4, 1'b1, 16'h011E, 16'h0000);
    chk("R1", "boot wp", wp, 16'h0100);
    chk("R1", "boot pc", pc, 16'h0200);
    chk("R1", "boot st", st, 16'h0000);
  endtask

  task automatic t_return;
    int bc; logic fz; int base;
    poke(16'h011A, 16'h0300);
    poke(16'h011C, 16'h0400);
    poke(16'h011E, 16'hC00F);
    base = log_n;
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    wait_done(bc, fz);
    chk("R5", "return accesses", 16'(log_n - base), 16'd3);
    chk_acc("R5", base,   1'b0, 16'h011A, 16'h0300);
    chk_acc("R5", base+1, 1'b0, 16'h011C, 16'h0400);
    chk_acc("R5", base+2, 1'b0, 16'h011E, 16'hC00F);
    chk("R5", "return wp", wp, 16'h0300);
    chk("R5", "return pc", pc, 16'h0400);
    chk("R5", "return st", st, 16'hC00F);
    chk("R4", "frozen during return", 16'(fz), 16'd1);
  endtask

  task automatic t_swap_waits;
    int bc; logic fz; int base;
    poke(16'h0040, 16'h0500);
    poke(16'h0042, 16'h0600);
    wait_cfg = 2;
    base = log_n;
    pulse_swap(16'h0041, 1'b0);
    wait_done(bc, fz);
    wait_cfg = 0;
    chk("R7", "busy cycles with 2 wait states", 16'(bc), 16'd15);
    chk("R4", "frozen during swap", 16'(fz), 16'd1);
    chk_acc("R2", base,   1'b0, 16'h0040, 16'h0500);
    chk_acc("R2", base+1, 1'b0, 16'h0042, 16'h0600);
    chk_acc("R3", base+2, 1'b1, 16'h051A, 16'h0300);
    chk_acc("R3", base+3, 1'b1, 16'h051C, 16'h0400);
    chk_acc("R3", base+4, 1'b1, 16'h051E, 16'hC00F);
    chk("R2", "swap wp", wp, 16'h0500);
    chk("R2", "swap pc", pc, 16'h0600);
    chk("R6", "swap keeps st", st, 16'hC00F);
  endtask

  task automatic t_priority;
    int bc; logic fz; int base;
    poke(16'h0060, 16'h0700);
    poke(16'h0062, 16'h0800);
    base = log_n;
    pulse_swap(16'h0060, 1'b1);
    wait_done(bc, fz);
    chk("R10", "accesses", 16'(log_n - base), 16'd5);
    chk_acc("R10", base, 1'b0, 16'h0060, 16'h0700);
    chk_acc("R10", base+2, 1'b1, 16'h071A, 16'h0500);
    chk("R10", "wp", wp, 16'h0700);
    chk("R10", "pc", pc, 16'h0800);
  endtask

  task automatic t_ignore_busy;
    int bc; logic fz; int base;
    poke(16'h071A, 16'h0100);
    poke(16'h071C, 16'h0900);
    poke(16'h071E, 16'h1234);
    base = log_n;
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    @(negedge clk); swap_req = 1'b1; swap_ea = 16'h0060;
    @(negedge clk); swap_req = 1'b0;
    wait_done(bc, fz);
    repeat (4) @(negedge clk);
    chk("R9", "busy after ignored request", 16'(busy), 16'd0);
    chk("R9", "accesses", 16'(log_n - base), 16'd3);
    chk("R9", "wp", wp, 16'h0100);
    chk("R9", "pc", pc, 16'h0900);
    chk("R9", "st", st, 16'h1234);
  endtask

  task automatic t_reset_abort;
    int bc; logic fz; int base;
    poke(16'h0080, 16'h0A00);
    poke(16'h0082, 16'h0B00);
    wait_cfg = 3;
    pulse_swap(16'h0080, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "abort busy", 16'(busy), 16'd0);
    chk("R11", "abort wp", wp, 16'h0000);
    chk("R11", "abort pc", pc, 16'h0000);
    chk("R11", "abort st", st, 16'h0000);
    wait_cfg = 0;
    base = log_n;
    @(negedge clk); rst_n = 1'b1;
    wait_done(bc, fz);
    chk_acc("R11", base, 1'b0, 16'h0000, 16'h0100);
    chk_acc("R11", base+4, 1'b1, 16'h011E, 16'h0000);
    chk("R11", "reentry wp", wp, 16'h0100);
    chk("R11", "reentry pc", pc, 16'h0200);
    chk("R11", "reentry st", st, 16'h0000);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_entry();
    t_return();
    t_swap_waits();
    t_priority();
    t_ignore_busy();
    t_reset_abort();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule